// File: doc/BRIEF.md
# DMA descriptor list walker

The walker steps through a list of 16-byte DMA descriptors in memory for a card-interface data engine. It fetches a whole descriptor in one response from a simple request/response memory port, and it decodes the control word and the two buffer sizes. For each buffer that holds data it issues one transfer command to an external data mover. When the mover reports that a buffer is done, it also reports card error flags. The walker ORs these flags into a summary bit and writes the control word back with the ownership bit cleared.

The next descriptor comes from one of three places. In chained mode it is the fourth descriptor word. When the end-of-ring bit is set on a non-chained descriptor, the walk returns to the programmed base address. Otherwise the next descriptor lies at the current address plus 16. The walker marks the first and last buffers of a transfer. It ends the walk after a descriptor flagged as last, and it raises a completion pulse unless that descriptor suppresses it. If it meets a descriptor that software has not handed over, the walker suspends and reports this. A later start then re-fetches that same descriptor.

Descriptor layout is as follows. Word 0 is the control word. Word 1 holds size 1 in bits 12:0 and size 2 in bits 25:13. Word 2 is buffer address 1. Word 3 is buffer address 2, or the next-descriptor address in chained mode. The response carries word 0 in bits 31:0 and word 3 in bits 127:96. The control-word bits used are:

| Bit | Meaning |
|-----|---------|
| 31 | Owned by the walker |
| 30 | Card error summary |
| 5 | End of ring |
| 4 | Chained |
| 3 | First |
| 2 | Last |
| 1 | No completion pulse |

Top module: `dsc_walker`

## Requirements
- R1: After `rst` or `soft_rst`, `walk_state` is 0 (idle) and `mem_req` and `xfer_valid` are low.
- R2: If a fetched control word has bit 31 at 0, the walker enters state 5 (suspended) and pulses `desc_unavail` for one cycle. A `start` while suspended re-fetches the same descriptor address, ignoring `base_addr`.
- R3: For a descriptor with bit 4 and bit 5 both clear and bit 2 clear, the next fetch address is the current address plus 16.
- R4: For a descriptor with bit 5 set and bit 4 clear, and not last, the next fetch address is `base_addr` as latched at the last start from idle.
- R5: For a descriptor with bit 4 set, the next fetch address is word 3, and bit 5 has no effect.
- R6: A chained descriptor with a nonzero size 2 pulses `desc_err`, returns to idle, and issues no transfer and no write-back.
- R7: Buffer 1 is commanded before buffer 2. Each command carries that buffer's address and size. A zero size is skipped without a command, and buffer 2 is never commanded in chained mode.
- R8: `xfer_first` is high on the first command issued at or after a descriptor with bit 3 set. If that descriptor's buffers are empty, the mark moves to the next descriptor's first nonzero buffer.
- R9: On a descriptor with bit 2 set, `xfer_last` is high on its last issued command. After its write-back the walker returns to idle.
- R10: After the write-back of a last descriptor, `cmplt_irq` pulses for one cycle unless bit 1 of that descriptor is set.
- R11: The write-back word is the fetched control word with bit 31 cleared and bit 30 equal to the OR of all `card_err` bits reported with `xfer_done` for that descriptor's buffers. All other bits are unchanged.
- R12: `walk_state` encodes idle=0, fetch=1, buffer 1=2, buffer 2=3, write-back=4, suspended=5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous return to idle |
| start | input | 1 | Begin a walk at `base_addr` from idle, or resume from suspended |
| base_addr | input | AW | List base address, also the ring wrap target |
| mem_req | output | 1 | Memory request, held until `mem_rsp_valid` |
| mem_we | output | 1 | 1 for the control-word write-back, 0 for a fetch |
| mem_addr | output | AW | Descriptor address |
| mem_wdata | output | 32 | Write-back control word |
| mem_rsp_valid | input | 1 | Memory response or write acknowledge |
| mem_rdata | input | 128 | Whole descriptor, word 0 in the low bits |
| xfer_valid | output | 1 | Transfer command valid, held until `xfer_done` |
| xfer_addr | output | 32 | Buffer address |
| xfer_len | output | 13 | Buffer size |
| xfer_first | output | 1 | First buffer of the transfer |
| xfer_last | output | 1 | Last buffer of the transfer |
| xfer_done | input | 1 | Mover finished the commanded buffer |
| card_err | input | 7 | Card error flags valid with `xfer_done` |
| desc_unavail | output | 1 | Pulse: descriptor not owned, walker suspended |
| desc_err | output | 1 | Pulse: malformed chained descriptor |
| cmplt_irq | output | 1 | Pulse: transfer complete |
| walk_state | output | 3 | Current state |

## Verification
The bench builds the walker with AW=10. All the list addresses, the ring wrap target and the chain pointers then fall inside a 16-entry descriptor memory model that is indexed by address bits 7:4. With this width, one run can cover a two-descriptor ring that wraps back onto a descriptor it has already released, and a chain that jumps past an end-of-ring bit. The same run covers a resume that must ignore a changed base address and a first marker carried over empty buffers. Error flags are injected for a single buffer address, so the write-back check can tell which descriptor took the summary bit.

// File: rtl/dsc_walker_pkg.sv
package dsc_walker_pkg;

    localparam int SZW        = 13;
    localparam int NERR       = 7;
    localparam int DESC_BYTES = 16;
    localparam int DESC_BITS  = 128;

    localparam int OWN_BIT   = 31;
    localparam int CES_BIT   = 30;
    localparam int RING_BIT  = 5;
    localparam int CHAIN_BIT = 4;
    localparam int FIRST_BIT = 3;
    localparam int LAST_BIT  = 2;
    localparam int NOIRQ_BIT = 1;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_BUF1  = 3'd2,
        ST_BUF2  = 3'd3,
        ST_WBACK = 3'd4,
        ST_SUSP  = 3'd5
    } wstate_e;

    typedef struct packed {
        logic [31:0]    ctrl;
        logic [SZW-1:0] sz1;
        logic [SZW-1:0] sz2;
        logic [31:0]    ptr1;
        logic [31:0]    ptr2;
    } desc_t;

    function automatic logic [31:0] wb_word(input logic [31:0] ctrl, input logic ces);
        logic [31:0] w;
        w = ctrl & ~(32'h1 << OWN_BIT) & ~(32'h1 << CES_BIT);
        return w | ({31'b0, ces} << CES_BIT);
    endfunction

endpackage

// File: rtl/dsc_decode.sv
module dsc_decode
    import dsc_walker_pkg::*;
(
    input  logic [DESC_BITS-1:0] raw,
    output desc_t                d,
    output logic                 owned,
    output logic                 malformed
);
    logic unused_rsvd;

    always_comb begin
        d.ctrl = raw[31:0];
        d.sz1  = raw[32 +: SZW];
        d.sz2  = raw[32 + SZW +: SZW];
        d.ptr1 = raw[95:64];
        d.ptr2 = raw[127:96];
    end

    assign owned       = raw[OWN_BIT];
    assign malformed   = raw[CHAIN_BIT] && (d.sz2 != '0);
    assign unused_rsvd = ^raw[63:32+2*SZW];
endmodule

// File: rtl/dsc_next_addr.sv
module dsc_next_addr
    import dsc_walker_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] chain_ptr,
    input  logic          chained,
    input  logic          ring_end,
    output logic [AW-1:0] next
);
    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    always_comb begin
        if (chained)       next = chain_ptr;
        else if (ring_end) next = base;
        else               next = cur + STEP;
    end
endmodule

// File: rtl/dsc_walker.sv
module dsc_walker
    import dsc_walker_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 soft_rst,
    input  logic                 start,
    input  logic [AW-1:0]        base_addr,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic                 mem_rsp_valid,
    input  logic [DESC_BITS-1:0] mem_rdata,
    output logic                 xfer_valid,
    output logic [31:0]          xfer_addr,
    output logic [SZW-1:0]       xfer_len,
    output logic                 xfer_first,
    output logic                 xfer_last,
    input  logic                 xfer_done,
    input  logic [NERR-1:0]      card_err,
    output logic                 desc_unavail,
    output logic                 desc_err,
    output logic                 cmplt_irq,
    output logic [2:0]           walk_state
);
    wstate_e       state;
    desc_t         desc;
    desc_t         dec;
    logic          dec_owned, dec_bad;
    logic [AW-1:0] cur_addr, base_q, next_addr;
    logic          err_acc, first_pend;
    logic          chained, sz1_nz, sz2_use;

    dsc_decode u_dec (
        .raw       (mem_rdata),
        .d         (dec),
        .owned     (dec_owned),
        .malformed (dec_bad)
    );

    dsc_next_addr #(.AW(AW)) u_nxt (
        .cur       (cur_addr),
        .base      (base_q),
        .chain_ptr (desc.ptr2[AW-1:0]),
        .chained   (chained),
        .ring_end  (desc.ctrl[RING_BIT]),
        .next      (next_addr)
    );

    assign chained = desc.ctrl[CHAIN_BIT];
    assign sz1_nz  = desc.sz1 != '0;
    assign sz2_use = !chained && (desc.sz2 != '0);

    assign mem_req    = (state == ST_FETCH) || (state == ST_WBACK);
    assign mem_we     = state == ST_WBACK;
    assign mem_addr   = cur_addr;
    assign mem_wdata  = wb_word(desc.ctrl, err_acc);
    assign xfer_valid = ((state == ST_BUF1) && sz1_nz) || ((state == ST_BUF2) && sz2_use);
    assign xfer_addr  = (state == ST_BUF2) ? desc.ptr2 : desc.ptr1;
    assign xfer_len   = (state == ST_BUF2) ? desc.sz2 : desc.sz1;
    assign xfer_first = first_pend;
    assign xfer_last  = desc.ctrl[LAST_BIT] && ((state == ST_BUF2) || !sz2_use);
    assign walk_state = state;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state        <= ST_IDLE;
            desc         <= '0;
            cur_addr     <= '0;
            base_q       <= '0;
            err_acc      <= 1'b0;
            first_pend   <= 1'b0;
            desc_unavail <= 1'b0;
            desc_err     <= 1'b0;
            cmplt_irq    <= 1'b0;
        end else begin
            desc_unavail <= 1'b0;
            desc_err     <= 1'b0;
            cmplt_irq    <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    cur_addr <= base_addr;
                    base_q   <= base_addr;
                    state    <= ST_FETCH;
                end
                ST_SUSP: if (start) state <= ST_FETCH;
                ST_FETCH: if (mem_rsp_valid) begin
                    if (!dec_owned) begin
                        state        <= ST_SUSP;
                        desc_unavail <= 1'b1;
                    end else if (dec_bad) begin
                        state    <= ST_IDLE;
                        desc_err <= 1'b1;
                    end else begin
                        desc    <= dec;
                        err_acc <= 1'b0;
                        if (dec.ctrl[FIRST_BIT]) first_pend <= 1'b1;
                        state   <= ST_BUF1;
                    end
                end
                ST_BUF1: begin
                    if (!sz1_nz) state <= ST_BUF2;
                    else if (xfer_done) begin
                        err_acc    <= err_acc | (|card_err);
                        first_pend <= 1'b0;
                        state      <= ST_BUF2;
                    end
                end
                ST_BUF2: begin
                    if (!sz2_use) state <= ST_WBACK;
                    else if (xfer_done) begin
                        err_acc    <= err_acc | (|card_err);
                        first_pend <= 1'b0;
                        state      <= ST_WBACK;
                    end
                end
                ST_WBACK: if (mem_rsp_valid) begin
                    if (desc.ctrl[LAST_BIT]) begin
                        state     <= ST_IDLE;
                        cmplt_irq <= !desc.ctrl[NOIRQ_BIT];
                    end else begin
                        cur_addr <= next_addr;
                        state    <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dsc_walker_chk.sv
module dsc_walker_chk
    import dsc_walker_pkg::*;
#(
    parameter int AW = 12
) (
    input logic           clk,
    input logic           rst,
    input logic           soft_rst,
    input logic           mem_req,
    input logic           mem_we,
    input logic [31:0]    mem_wdata,
    input logic           xfer_valid,
    input logic [31:0]    xfer_addr,
    input logic [SZW-1:0] xfer_len,
    input logic           xfer_done,
    input logic           desc_unavail,
    input logic           desc_err,
    input logic           cmplt_irq,
    input logic [2:0]     walk_state,
    input logic [AW-1:0]  mem_addr
);
    // R1
    soft_idle_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (walk_state == 3'd0) && !mem_req && !xfer_valid);

    // R2
    unavail_susp_chk: assert property (@(posedge clk) disable iff (rst)
        desc_unavail |-> walk_state == 3'd5);

    // R6
    bad_desc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        desc_err |-> (walk_state == 3'd0) && !xfer_valid && !mem_req);

    // R7
    xfer_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (xfer_len != '0) && ((walk_state == 3'd2) || (walk_state == 3'd3)));

    // R7
    xfer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer_done && !soft_rst) |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_len));

    // R10
    irq_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
        cmplt_irq |-> ($past(walk_state) == 3'd4) && (walk_state == 3'd0));

    // R11
    wb_own_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

    // R11
    wb_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !soft_rst && $past(mem_req && mem_we)) |-> $stable(mem_addr));
endmodule

bind dsc_walker dsc_walker_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .soft_rst     (soft_rst),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .xfer_valid   (xfer_valid),
    .xfer_addr    (xfer_addr),
    .xfer_len     (xfer_len),
    .xfer_done    (xfer_done),
    .desc_unavail (desc_unavail),
    .desc_err     (desc_err),
    .cmplt_irq    (cmplt_irq),
    .walk_state   (walk_state),
    .mem_addr     (mem_addr)
);

// File: tb/tb_dsc_walker.sv
module tb_dsc_walker;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst = 1'b1, soft_rst = 1'b0, start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic mem_req, mem_we, mem_rsp_valid = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic xfer_valid, xfer_first, xfer_last, xfer_done = 1'b0;
    logic [31:0] xfer_addr;
    logic [12:0] xfer_len;
    logic [6:0] card_err = '0;
    logic desc_unavail, desc_err, cmplt_irq;
    logic [2:0] walk_state;

    always #5 clk = ~clk;

    dsc_walker #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .start(start), .base_addr(base_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
        .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_first(xfer_first), .xfer_last(xfer_last), .xfer_done(xfer_done),
        .card_err(card_err), .desc_unavail(desc_unavail), .desc_err(desc_err),
        .cmplt_irq(cmplt_irq), .walk_state(walk_state)
    );

    int total = 0, bad = 0, cyc = 0;
    int irq_n = 0, unav_n = 0, err_n = 0, mcnt = 0, xcnt = 0;
    logic mover_en = 1'b1;
    logic [31:0] inj_addr = '1;
    logic [6:0] inj_err = '0;
    logic [127:0] dmem [16];

    typedef struct { logic [31:0] a; logic [12:0] l; logic f; logic la; } exp_t;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input int addr, input logic [31:0] ctrl, input logic [12:0] s1,
                            input logic [12:0] s2, input logic [31:0] p1, input logic [31:0] p2);
        dmem[addr[7:4]] = {p2, p1, 6'b0, s2, s1, ctrl};
    endtask

    task automatic exp_push(input logic [31:0] a, input logic [12:0] l, input logic f, input logic la);
        exp_t e;
        e.a = a; e.l = l; e.f = f; e.la = la;
        exp_q.push_back(e);
    endtask

    task automatic run_walk(input int base);
        @(negedge clk);
        base_addr = AW'(base);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(walk_state == 3'd0 || walk_state == 3'd5)) @(negedge clk);
        @(negedge clk);
    endtask

    // memory model: two-cycle latency, whole descriptor per read
    always @(negedge clk) begin
        if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
            mcnt = 0;
        end else if (mem_req) begin
            if (mcnt == 1) begin
                mcnt = 0;
                mem_rsp_valid = 1'b1;
                if (mem_we) dmem[mem_addr[7:4]][31:0] = mem_wdata;
                else        mem_rdata = dmem[mem_addr[7:4]];
            end else mcnt++;
        end else mcnt = 0;
    end

    // mover model and scoreboard monitor
    always @(negedge clk) begin
        if (xfer_done) begin
            xfer_done = 1'b0;
            card_err = '0;
        end else if (xfer_valid && mover_en) begin
            if (xcnt == 2) begin
                xcnt = 0;
                xfer_done = 1'b1;
                card_err = (xfer_addr == inj_addr) ? inj_err : 7'h0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected command", xfer_addr, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(xfer_addr == e.a, "R7 buffer address", xfer_addr, e.a);
                    chk(xfer_len == e.l, "R7 buffer size", 32'(xfer_len), 32'(e.l));
                    chk(xfer_first == e.f, "R8 first mark", 32'(xfer_first), 32'(e.f));
                    chk(xfer_last == e.la, "R9 last mark", 32'(xfer_last), 32'(e.la));
                end
            end else xcnt++;
        end else xcnt = 0;
    end

    always @(negedge clk) begin
        if (!rst) begin
            irq_n  += int'(cmplt_irq);
            unav_n += int'(desc_unavail);
            err_n  += int'(desc_err);
        end
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL R1 watchdog actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) dmem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(walk_state == 3'd0, "R1 reset state", 32'(walk_state), 0);
        chk(!mem_req && !xfer_valid, "R1 reset idle outputs", 32'({mem_req, xfer_valid}), 0);

        // sequential pair, both buffers, skip of empty size 1
        put_desc(32'h00, 32'h8000_0008, 13'd100, 13'd50, 32'h400, 32'h500);
        put_desc(32'h10, 32'h8000_0024, 13'd0,   13'd20, 32'h480, 32'h600);
        exp_push(32'h400, 13'd100, 1'b1, 1'b0);
        exp_push(32'h500, 13'd50,  1'b0, 1'b0);
        exp_push(32'h600, 13'd20,  1'b0, 1'b1);
        run_walk(32'h00);
        chk(exp_q.size() == 0, "R3 sequential walk consumed", exp_q.size(), 0);
        chk(walk_state == 3'd0, "R9 idle after last", 32'(walk_state), 0);
        chk(irq_n == 1, "R10 completion pulse", irq_n, 1);
        chk(dmem[0][31:0] == 32'h0000_0008, "R11 write-back clean", dmem[0][31:0], 32'h8);
        chk(dmem[1][31:0] == 32'h0000_0024, "R11 write-back last", dmem[1][31:0], 32'h24);

        // ring wrap onto a released descriptor, then resume
        put_desc(32'h30, 32'h8000_0008, 13'd8, 13'd0, 32'h700, 32'h0);
        put_desc(32'h40, 32'h8000_0020, 13'd4, 13'd0, 32'h710, 32'h0);
        exp_push(32'h700, 13'd8, 1'b1, 1'b0);
        exp_push(32'h710, 13'd4, 1'b0, 1'b0);
        run_walk(32'h30);
        chk(exp_q.size() == 0, "R4 ring commands consumed", exp_q.size(), 0);
        chk(walk_state == 3'd5, "R2 suspended on wrap", 32'(walk_state), 5);
        chk(unav_n == 1, "R4 wrap fetched base, unavailable", unav_n, 1);
        put_desc(32'h30, 32'h8000_0004, 13'd2, 13'd0, 32'h720, 32'h0);
        exp_push(32'h720, 13'd2, 1'b0, 1'b1);
        run_walk(32'h00);
        chk(exp_q.size() == 0, "R2 resume refetch consumed", exp_q.size(), 0);
        chk(walk_state == 3'd0 && unav_n == 1, "R2 resume ignores base", 32'(walk_state), 0);
        chk(irq_n == 2, "R10 pulse after resume", irq_n, 2);

        // chained, end-of-ring ignored, suppressed pulse, error summary
        put_desc(32'h50, 32'h8000_0038, 13'd12, 13'd0, 32'h800, 32'h80);
        put_desc(32'h80, 32'h8000_0016, 13'd6,  13'd0, 32'h900, 32'h0);
        inj_addr = 32'h900;
        inj_err = 7'h04;
        exp_push(32'h800, 13'd12, 1'b1, 1'b0);
        exp_push(32'h900, 13'd6,  1'b0, 1'b1);
        run_walk(32'h50);
        inj_addr = '1;
        chk(exp_q.size() == 0, "R5 chain commands consumed", exp_q.size(), 0);
        chk(walk_state == 3'd0 && unav_n == 1, "R5 ring bit ignored in chain", 32'(walk_state), 0);
        chk(irq_n == 2, "R10 pulse suppressed", irq_n, 2);
        chk(dmem[5][31:0] == 32'h0000_0038, "R11 no error summary", dmem[5][31:0], 32'h38);
        chk(dmem[8][31:0] == 32'h4000_0016, "R11 error summary set", dmem[8][31:0], 32'h4000_0016);

        // malformed chained descriptor
        put_desc(32'h90, 32'h8000_0010, 13'd4, 13'd5, 32'hA80, 32'h0);
        run_walk(32'h90);
        chk(err_n == 1, "R6 error pulse", err_n, 1);
        chk(walk_state == 3'd0, "R6 back to idle", 32'(walk_state), 0);
        chk(dmem[9][31:0] == 32'h8000_0010, "R6 no write-back", dmem[9][31:0], 32'h8000_0010);

        // first mark carried past empty buffers
        put_desc(32'hA0, 32'h8000_0008, 13'd0, 13'd0, 32'h0, 32'h0);
        put_desc(32'hB0, 32'h8000_0004, 13'd3, 13'd0, 32'hA00, 32'h0);
        exp_push(32'hA00, 13'd3, 1'b1, 1'b1);
        run_walk(32'hA0);
        chk(exp_q.size() == 0, "R8 carried first consumed", exp_q.size(), 0);
        chk(irq_n == 3, "R10 pulse single buffer", irq_n, 3);

        // soft reset during a buffer
        mover_en = 1'b0;
        put_desc(32'hC0, 32'h8000_0004, 13'd5, 13'd0, 32'hB00, 32'h0);
        @(negedge clk);
        base_addr = AW'(32'hC0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (walk_state != 3'd2) @(negedge clk);
        chk(xfer_valid == 1'b1, "R12 buffer state encoding", 32'(xfer_valid), 1);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk(walk_state == 3'd0, "R1 soft reset state", 32'(walk_state), 0);
        chk(!xfer_valid && !mem_req, "R1 soft reset outputs", 32'({xfer_valid, mem_req}), 0);
        mover_en = 1'b1;
        repeat (4) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule